// File: doc/BRIEF.md
# Gate-Drive Undervoltage Lockout Supervisor

This block is the digital sequencer that decides whether a gate-driver channel may switch. It reads comparator flags already brought into the clock domain. Each drive rail, positive and negative, provides two flags: one for "below the release-off level" and one for "above the restart level". When a rail drops below its off level for long enough, the block forces the gate-control code into a safe state. It holds that safe state until the rails have recovered cleanly.

The block filters short supply dips by duration. A dip must last a full trip count of consecutive cycles before the gate is taken out of drive. Recovery has two stages. The rails must first sit above their restart levels for an unbroken stability window. After that, the channel resumes on its own, or, in latched mode, waits for the operator to cycle the enable. The safe code used depends on which rail failed, and policy inputs choose it. An active-low fault flag mirrors the lockout condition, and a status code exposes the controller state.

Top module: `uvlo_supervisor`

## Requirements
- R1: After reset the status reads LOCKOUT (code 2), the fault flag is low, and the gate code is the global safe code, because both rails are taken as failed at reset.
- R2: A run of below-off samples shorter than TRIP_CYC cycles leaves the gate code and fault flag unchanged. Runs shorter than IGNORE_CYC are included. The status goes through DIP_FILTER (code 1) and then returns to ACTIVE (code 0).
- R3: The edge that samples the TRIP_CYC-th consecutive below-off cycle moves the status to LOCKOUT. From that edge on, the gate code is a safe code and the fault flag is low.
- R4: In lockout, the safe code is chosen by the rails that are below off. Gate codes are: 0 drive, 1 low, 2 high-impedance, 3 clamp.
  - Positive rail alone: code 2 when pos_hiz_sel is 1, else 1.
  - Negative rail alone: code 3 when neg_clamp_sel is 1, else 1.
  - Both rails: glob_sel gives the code (00→1, 01→2, 1x→3).
  - The code chosen last is held once the rails are back above off.
- R5: In auto mode (latch_mode=0), the status goes from LOCKOUT through STABILIZE (code 3) to ACTIVE. This happens on the edge that samples the STABLE_CYC-th consecutive cycle with every monitored rail above on and none below off.
- R6: Any cycle inside the stability window in which a rail is not above on returns the status to LOCKOUT and restarts the count. The gate stays in the safe state.
- R7: In latched mode, a finished stability window leads to LATCHED_WAIT_EN (code 4), and the gate stays safe. ACTIVE is reached only when en_dis_n is sampled high and then low on the next edge while waiting.
- R8: When not locked out, en_dis_n=1 gives gate code 1 and en_dis_n=0 gives code 0. During lockout, en_dis_n has no effect on the gate code.
- R9: The fault flag is low exactly in LOCKOUT, STABILIZE and LATCHED_WAIT_EN, and high in ACTIVE and DIP_FILTER.
- R10: A rail inside the hysteresis band (neither below off nor above on) never releases lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_below_off | input | 1 | Positive rail under its off level |
| pos_above_on | input | 1 | Positive rail over its restart level |
| neg_below_off | input | 1 | Negative rail under its off level |
| neg_above_on | input | 1 | Negative rail over its restart level |
| en_dis_n | input | 1 | External enable, low = drive allowed |
| latch_mode | input | 1 | 1 = latched recovery, 0 = auto recovery |
| pos_hiz_sel | input | 1 | Positive-rail safe code: 1 high-impedance, 0 low |
| neg_clamp_sel | input | 1 | Negative-rail safe code: 1 clamp, 0 low |
| glob_sel | input | 2 | Both-rail safe code select |
| gate_ctl | output | 2 | Gate control code |
| fault_n | output | 1 | Active-low lockout flag |
| state_o | output | 3 | Controller status code |

## Verification
The properties assume that the comparator flags for one rail are consistent, so that below-off and above-on are never both high. They also assume that the flags are synchronous to clk and change only between edges. The stimulus respects both assumptions: a rail is lowered by raising below-off and clearing above-on in the same cycle, and the hysteresis band is entered by clearing both. Inputs are applied just after the falling clock edge. This keeps every flag stable around the sampling edge that the trip and stability counters depend on.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_DIP    = 3'd1,
      ST_LOCK   = 3'd2,
      ST_STAB   = 3'd3,
      ST_WAIT   = 3'd4
   } sup_state_t;

   typedef enum logic [1:0] {
      GC_DRIVE = 2'd0,
      GC_LOW   = 2'd1,
      GC_HIZ   = 2'd2,
      GC_CLAMP = 2'd3
   } gate_code_t;

   function automatic gate_code_t glob_code(input logic [1:0] sel);
      if (sel[1])      return GC_CLAMP;
      else if (sel[0]) return GC_HIZ;
      else             return GC_LOW;
   endfunction

   function automatic logic is_locked(input sup_state_t s);
      return (s == ST_LOCK) || (s == ST_STAB) || (s == ST_WAIT);
   endfunction

endpackage

// File: rtl/uvlo_rail_qual.sv
module uvlo_rail_qual #(
   parameter int NEG_RAIL_EN = 1
) (
   input  logic       pos_below_off,
   input  logic       pos_above_on,
   input  logic       neg_below_off,
   input  logic       neg_above_on,
   output logic [1:0] low_vec,
   output logic       rail_low,
   output logic       rails_ok
);

   logic neg_low;
   logic neg_ok;

   generate
      if (NEG_RAIL_EN != 0) begin : g_neg_mon
         assign neg_low = neg_below_off;
         assign neg_ok  = neg_above_on & ~neg_below_off;
      end else begin : g_neg_off
         logic unused_neg;
         assign unused_neg = neg_below_off ^ neg_above_on;
         assign neg_low    = 1'b0;
         assign neg_ok     = 1'b1;
      end
   endgenerate

   assign low_vec  = {neg_low, pos_below_off};
   assign rail_low = |low_vec;
   assign rails_ok = pos_above_on & ~pos_below_off & neg_ok;

endmodule

// File: rtl/uvlo_ctrl_fsm.sv
module uvlo_ctrl_fsm
   import uvlo_pkg::*;
#(
   parameter int TRIP_CYC   = 8,
   parameter int STABLE_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rail_low,
   input  logic       rails_ok,
   input  logic [1:0] low_vec,
   input  logic       en_dis_n,
   input  logic       latch_mode,
   output sup_state_t state,
   output logic [1:0] cause
);

   localparam int MAXC = (TRIP_CYC > STABLE_CYC) ? TRIP_CYC : STABLE_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] TRIP_C = CW'(TRIP_CYC);
   localparam logic [CW-1:0] STAB_C = CW'(STABLE_CYC);

   sup_state_t    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
   logic [1:0]    cause_q, cause_d;
   logic          en_q;

   assign cnt_inc = cnt_q + CW'(1);

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      cause_d = cause_q;
      unique case (st_q)
         ST_ACTIVE, ST_DIP: begin
            if (rail_low) begin
               if (cnt_inc >= TRIP_C) begin
                  st_d  = ST_LOCK;
                  cnt_d = '0;
               end else begin
                  st_d  = ST_DIP;
                  cnt_d = cnt_inc;
               end
            end else begin
               st_d  = ST_ACTIVE;
               cnt_d = '0;
            end
         end
         ST_LOCK, ST_STAB: begin
            if (rails_ok) begin
               if (cnt_inc >= STAB_C) begin
                  st_d  = latch_mode ? ST_WAIT : ST_ACTIVE;
                  cnt_d = '0;
               end else begin
                  st_d  = ST_STAB;
                  cnt_d = cnt_inc;
               end
            end else begin
               st_d  = ST_LOCK;
               cnt_d = '0;
            end
         end
         ST_WAIT: begin
            cnt_d = '0;
            if (!rails_ok)              st_d = ST_LOCK;
            else if (en_q && !en_dis_n) st_d = ST_ACTIVE;
         end
         default: begin
            st_d  = ST_LOCK;
            cnt_d = '0;
         end
      endcase
      if (rail_low && (is_locked(st_q) || st_d == ST_LOCK))
         cause_d = low_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_LOCK;
         cnt_q   <= '0;
         cause_q <= 2'b11;
         en_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         cause_q <= cause_d;
         en_q    <= en_dis_n;
      end
   end

   assign state = st_q;
   assign cause = cause_q;

endmodule

// File: rtl/uvlo_safe_map.sv
module uvlo_safe_map
   import uvlo_pkg::*;
(
   input  sup_state_t state,
   input  logic [1:0] cause,
   input  logic       en_dis_n,
   input  logic       pos_hiz_sel,
   input  logic       neg_clamp_sel,
   input  logic [1:0] glob_sel,
   output gate_code_t gate,
   output logic       fault_n
);

   logic locked;
   assign locked = is_locked(state);

   always_comb begin
      if (!locked) begin
         gate = en_dis_n ? GC_LOW : GC_DRIVE;
      end else begin
         unique case (cause)
            2'b01:   gate = pos_hiz_sel   ? GC_HIZ   : GC_LOW;
            2'b10:   gate = neg_clamp_sel ? GC_CLAMP : GC_LOW;
            default: gate = glob_code(glob_sel);
         endcase
      end
   end

   assign fault_n = ~locked;

endmodule

// File: rtl/uvlo_supervisor.sv
module uvlo_supervisor
   import uvlo_pkg::*;
#(
   parameter int IGNORE_CYC  = 4,
   parameter int TRIP_CYC    = 8,
   parameter int STABLE_CYC  = 16,
   parameter int NEG_RAIL_EN = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pos_below_off,
   input  logic       pos_above_on,
   input  logic       neg_below_off,
   input  logic       neg_above_on,
   input  logic       en_dis_n,
   input  logic       latch_mode,
   input  logic       pos_hiz_sel,
   input  logic       neg_clamp_sel,
   input  logic [1:0] glob_sel,
   output logic [1:0] gate_ctl,
   output logic       fault_n,
   output logic [2:0] state_o
);

   generate
      if (IGNORE_CYC < 1)        begin : g_bad_ign  $error("IGNORE_CYC must be at least 1"); end
      if (TRIP_CYC < IGNORE_CYC) begin : g_bad_trip $error("TRIP_CYC must not be below IGNORE_CYC"); end
      if (STABLE_CYC < 1)        begin : g_bad_stab $error("STABLE_CYC must be at least 1"); end
   endgenerate

   logic [1:0] low_vec;
   logic       rail_low;
   logic       rails_ok;
   sup_state_t state;
   logic [1:0] cause;
   gate_code_t gate;

   uvlo_rail_qual #(.NEG_RAIL_EN(NEG_RAIL_EN)) u_qual (
      .pos_below_off (pos_below_off),
      .pos_above_on  (pos_above_on),
      .neg_below_off (neg_below_off),
      .neg_above_on  (neg_above_on),
      .low_vec       (low_vec),
      .rail_low      (rail_low),
      .rails_ok      (rails_ok)
   );

   uvlo_ctrl_fsm #(.TRIP_CYC(TRIP_CYC), .STABLE_CYC(STABLE_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rail_low   (rail_low),
      .rails_ok   (rails_ok),
      .low_vec    (low_vec),
      .en_dis_n   (en_dis_n),
      .latch_mode (latch_mode),
      .state      (state),
      .cause      (cause)
   );

   uvlo_safe_map u_map (
      .state         (state),
      .cause         (cause),
      .en_dis_n      (en_dis_n),
      .pos_hiz_sel   (pos_hiz_sel),
      .neg_clamp_sel (neg_clamp_sel),
      .glob_sel      (glob_sel),
      .gate          (gate),
      .fault_n       (fault_n)
   );

   assign gate_ctl = gate;
   assign state_o  = state;

endmodule

// File: rtl/uvlo_supervisor_chk.sv
module uvlo_supervisor_chk #(
   parameter int NEG_RAIL_EN = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pos_below_off,
   input logic       pos_above_on,
   input logic       neg_below_off,
   input logic       neg_above_on,
   input logic       en_dis_n,
   input logic       latch_mode,
   input logic [1:0] gate_ctl,
   input logic       fault_n,
   input logic [2:0] state_o
);

   logic low_now, ok_now, run_st, lock_st;
   assign low_now = pos_below_off | ((NEG_RAIL_EN != 0) & neg_below_off);
   assign ok_now  = pos_above_on & ~pos_below_off &
                    ((NEG_RAIL_EN == 0) | (neg_above_on & ~neg_below_off));
   assign run_st  = (state_o == 3'd0) || (state_o == 3'd1);
   assign lock_st = (state_o == 3'd2) || (state_o == 3'd3) || (state_o == 3'd4);

   p_state_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 3'd4);

   p_lock_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_st |-> (!fault_n && gate_ctl != 2'd0));

   p_run_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_st |-> fault_n);

   p_trip_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2 && ($past(state_o) == 3'd0 || $past(state_o) == 3'd1)) |-> $past(low_now));

   p_auto_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && $past(state_o) == 3'd3) |-> ($past(ok_now) && !$past(latch_mode)));

   p_latch_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && $past(state_o) == 3'd4) |-> (!$past(en_dis_n) && $past(en_dis_n, 2)));

   p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_st && en_dis_n) |-> gate_ctl == 2'd1);

   p_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0) |=> (state_o <= 3'd2));

   p_band_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2 && !ok_now) |=> (state_o == 3'd2));

endmodule

bind uvlo_supervisor uvlo_supervisor_chk #(.NEG_RAIL_EN(NEG_RAIL_EN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pos_below_off (pos_below_off),
   .pos_above_on  (pos_above_on),
   .neg_below_off (neg_below_off),
   .neg_above_on  (neg_above_on),
   .en_dis_n      (en_dis_n),
   .latch_mode    (latch_mode),
   .gate_ctl      (gate_ctl),
   .fault_n       (fault_n),
   .state_o       (state_o)
);

// File: tb/sim_uvlo_supervisor.sv
module sim_uvlo_supervisor;

   localparam int IGN  = 4;
   localparam int TRIP = 8;
   localparam int STAB = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic pb, pa, nb, na, en, lm, psel, nsel;
   logic [1:0] glob;
   logic [1:0] gate_ctl;
   logic       fault_n;
   logic [2:0] state_o;

   // staged inputs, applied by step()
   logic x_pb = 1, x_pa = 0, x_nb = 1, x_na = 0, x_en = 0, x_lm = 0, x_psel = 1, x_nsel = 1;
   logic [1:0] x_glob = 2'b10;

   uvlo_supervisor #(.IGNORE_CYC(IGN), .TRIP_CYC(TRIP), .STABLE_CYC(STAB), .NEG_RAIL_EN(1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .pos_below_off(pb), .pos_above_on(pa), .neg_below_off(nb), .neg_above_on(na),
      .en_dis_n(en), .latch_mode(lm), .pos_hiz_sel(psel), .neg_clamp_sel(nsel),
      .glob_sel(glob), .gate_ctl(gate_ctl), .fault_n(fault_n), .state_o(state_o));

   typedef struct { int st; int gate; int flt; string tag; } exp_t;
   exp_t sbq[$];
   int n_cmp = 0;
   int n_bad = 0;

   // requirement-level reference: 0 ACTIVE 1 DIP 2 LOCK 3 STAB 4 WAIT
   int m_st = 2, m_cnt = 0, m_cause = 3;
   logic m_enq = 1'b0;

   function automatic int m_gate();
      if (m_st <= 1) return en ? 1 : 0;
      if (m_cause == 1) return psel ? 2 : 1;
      if (m_cause == 2) return nsel ? 3 : 1;
      if (glob[1]) return 3;
      return glob[0] ? 2 : 1;
   endfunction

   task automatic model_edge();
      logic lo, ok;
      int nx;
      lo = pb | nb;
      ok = pa & na & ~lo;
      nx = m_st;
      if (m_st <= 1) begin
         if (lo) begin
            if (m_cnt + 1 >= TRIP) begin nx = 2; m_cnt = 0; end
            else begin nx = 1; m_cnt = m_cnt + 1; end
         end else begin nx = 0; m_cnt = 0; end
      end else if (m_st == 2 || m_st == 3) begin
         if (ok) begin
            if (m_cnt + 1 >= STAB) begin nx = lm ? 4 : 0; m_cnt = 0; end
            else begin nx = 3; m_cnt = m_cnt + 1; end
         end else begin nx = 2; m_cnt = 0; end
      end else begin
         m_cnt = 0;
         if (!ok) nx = 2;
         else if (m_enq && !en) nx = 0;
      end
      if (lo && (m_st >= 2 || nx == 2)) m_cause = {30'd0, nb, pb};
      m_st  = nx;
      m_enq = en;
   endtask

   task automatic step(input string tag);
      exp_t e;
      @(negedge clk); #1;
      pb = x_pb; pa = x_pa; nb = x_nb; na = x_na; en = x_en;
      lm = x_lm; psel = x_psel; nsel = x_nsel; glob = x_glob;
      model_edge();
      @(posedge clk); #1;
      e.st = m_st; e.gate = m_gate(); e.flt = (m_st <= 1) ? 1 : 0; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic expect_now(input string tag, input int st, input int g, input int f);
      n_cmp++;
      if (int'(state_o) != st || int'(gate_ctl) != g || int'(fault_n) != f) begin
         n_bad++;
         $display("FAIL %s: actual st=%0d gate=%0d flt=%0d expected st=%0d gate=%0d flt=%0d",
                  tag, state_o, gate_ctl, fault_n, st, g, f);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         n_cmp++;
         if (int'(state_o) != e.st || int'(gate_ctl) != e.gate || int'(fault_n) != e.flt) begin
            n_bad++;
            $display("FAIL %s: actual st=%0d gate=%0d flt=%0d expected st=%0d gate=%0d flt=%0d",
                     e.tag, state_o, gate_ctl, fault_n, e.st, e.gate, e.flt);
         end
      end
   end

   initial begin
      pb = x_pb; pa = x_pa; nb = x_nb; na = x_na; en = x_en;
      lm = x_lm; psel = x_psel; nsel = x_nsel; glob = x_glob;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1 expect_now("R1 reset", 2, 3, 0);
      run(3, "R1");
      // hysteresis band: neither below off nor above on
      x_pb = 0; x_nb = 0;
      run(10, "R10");
      expect_now("R10 band", 2, 3, 0);
      // clean rails, auto recovery
      x_pa = 1; x_na = 1;
      run(STAB - 1, "R5");
      expect_now("R5 window", 3, 3, 0);
      run(1, "R5");
      expect_now("R5 release", 0, 0, 1);
      // external disable
      x_en = 1; run(3, "R8");
      expect_now("R8 disable", 0, 1, 1);
      x_en = 0; run(1, "R8");
      // short dips ignored
      x_pb = 1; x_pa = 0; run(IGN - 1, "R2");
      x_pb = 0; x_pa = 1; run(2, "R2");
      x_pb = 1; x_pa = 0; run(TRIP - 1, "R2");
      x_pb = 0; x_pa = 1; run(1, "R2");
      expect_now("R2 dip", 0, 0, 1);
      // full-length dip trips
      x_pb = 1; x_pa = 0; run(TRIP - 1, "R3");
      expect_now("R3 filter", 1, 0, 1);
      run(1, "R3");
      expect_now("R3 trip", 2, 2, 0);
      x_en = 1; run(2, "R8");
      expect_now("R8 locked", 2, 2, 0);
      x_en = 0;
      // stability restart
      x_pb = 0; x_pa = 1; run(STAB / 2, "R6");
      x_na = 0; run(1, "R6");
      expect_now("R6 restart", 2, 2, 0);
      x_na = 1; run(STAB - 1, "R6");
      expect_now("R6 window", 3, 2, 0);
      run(1, "R6");
      expect_now("R6 release", 0, 0, 1);
      // per-rail mapping
      x_nb = 1; x_na = 0; run(TRIP, "R4");
      expect_now("R4 neg", 2, 3, 0);
      x_nsel = 0; run(1, "R4");
      expect_now("R4 neg low", 2, 1, 0);
      x_nsel = 1; x_pb = 1; x_pa = 0; run(1, "R4");
      expect_now("R4 both", 2, 3, 0);
      x_glob = 2'b01; run(1, "R4");
      expect_now("R4 glob", 2, 2, 0);
      // latched recovery
      x_lm = 1; x_pb = 0; x_pa = 1; x_nb = 0; x_na = 1;
      run(STAB, "R7");
      expect_now("R7 wait", 4, 2, 0);
      run(5, "R7");
      x_en = 1; run(2, "R7");
      expect_now("R7 held", 4, 2, 0);
      x_en = 0; run(1, "R7");
      expect_now("R7 release", 0, 0, 1);
      // positive rail with low mapping, status and flag
      x_psel = 0; x_pb = 1; x_pa = 0; run(TRIP, "R9");
      expect_now("R9 lock", 2, 1, 0);
      x_pb = 0; x_pa = 1; run(STAB + 3, "R9");
      x_en = 1; run(1, "R9"); x_en = 0; run(2, "R9");
      @(negedge clk); @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule